// File: doc/BRIEF.md
# Absolute Encoder Reply Receiver

This block takes the serial answer an absolute rotary encoder sends back on its half-duplex data line after the master has issued a request. The line idles high and carries asynchronous byte frames. Each frame is timed by an oversampling enable that runs at eight times the bit rate. After a start strobe, the receiver looks up how many frames the current data ID produces and collects exactly that many. It then places each byte into a named output register and raises a one-cycle completion pulse.

The last frame of every reply is a check byte. The receiver runs an 8-bit check over every earlier byte of the reply and compares the result with that check byte. It reports the outcome on a flag that stays valid until the next accepted start. Two faults end a reply early: a bad stop bit, and a stall between frames longer than a programmable limit. Each fault sets its own flag and still produces the completion pulse, so the controller above always sees each transaction end.

Top module: `enc_reply_rx`

## Requirements
- R1: The frame count is set by `data_id`. IDs 0x0, 0x1, 0x7, 0x8 and 0xC expect 6 frames. IDs 0x2, 0x6 and 0xD expect 4 frames. ID 0x3 expects 11 frames. `done` pulses only after the last expected frame, never earlier.
- R2: For IDs 0x0, 0x7, 0x8 and 0xC, the fields are placed by frame index. Frame 0 goes to `ctrl_field`, frame 1 to `status_field` and frame 5 to `crc_field`. Frames 2, 3 and 4 become `turn_pos` bits 7:0, 15:8 and 23:16, so the first byte received is the least significant.
- R3: ID 0x1 uses the same frame order as R2, except that frames 2 to 4 fill `multi_turn` (least significant byte first) and `turn_pos` is left untouched.
- R4: ID 0x2 places frame 1 in `status_field` and frame 2 in `enc_ident`. ID 0x3 places frame 1 in `status_field` and frames 2 to 4 in `turn_pos`, least significant byte first. It places frame 5 in `enc_ident`, frames 6 to 8 in `multi_turn` (least significant byte first), frame 9 in `alarm_field` and frame 10 in `crc_field`.
- R5: IDs 0x6 and 0xD (memory write and read replies) place frame 1 in `ee_addr`, frame 2 in `ee_data` and frame 3 in `crc_field`.
- R6: The check value starts at 0x00 and takes each byte MSB first. For each bit, the feedback is the data bit XOR check bit 7; the check value shifts left one place and the feedback enters bit 0 (polynomial x^8+1). It covers all frames except the last. `crc_ok` is 1 after completion exactly when the value equals the last frame; the last frame always appears on `crc_field`.
- R7: A frame is a start bit of 0, then 8 data bits LSB first, then a stop bit of 1. A stop bit sampled as 0 sets `frame_err`, pulses `done` and ends the reply with `crc_ok` at 0.
- R8: A falling edge becomes a start bit only if the line is still low at the fourth oversampling tick after the edge was seen. The data bits and the stop bit are sampled every eight ticks after that point. A shorter low glitch is discarded.
- R9: If no frame completes within `timeout_limit` clock cycles of the start or of the previous frame, `timeout` is set and `done` pulses, with `crc_ok` at 0.
- R10: After reset, all field registers and flags read 0. An accepted start clears every field register and the three flags, so fields that the new data ID does not carry read 0.
- R11: A start with any data ID not listed in R1 is ignored. No `done` follows, and all outputs keep their values.
- R12: `done` is high for exactly one clock cycle per reply. At most one of `crc_ok`, `frame_err` and `timeout` is set when it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling enable, eight pulses per bit time |
| rx_line | input | 1 | Serial data from the encoder, idles high |
| data_id | input | 4 | Data ID of the outstanding request |
| start | input | 1 | Starts a reception, accepted when idle |
| timeout_limit | input | TO_W | Allowed clock cycles without a completed frame |
| ctrl_field | output | 8 | Control byte echoed by the encoder |
| status_field | output | 8 | Status byte |
| turn_pos | output | POS_W | Single-turn position |
| multi_turn | output | POS_W | Multi-turn count |
| enc_ident | output | 8 | Encoder identification byte |
| alarm_field | output | 8 | Alarm byte |
| ee_addr | output | 8 | Memory address echoed in memory replies |
| ee_data | output | 8 | Memory data in memory replies |
| crc_field | output | 8 | Check byte as received |
| done | output | 1 | One-cycle completion pulse |
| crc_ok | output | 1 | Computed check value matched the received one |
| frame_err | output | 1 | A stop bit was received as 0 |
| timeout | output | 1 | The reply stalled beyond the limit |

## Verification
The bench checks the byte order of the 24-bit fields with byte values whose bits are asymmetric. A receiver that assembles the position most significant byte first, or shifts data in MSB first, shows a different `turn_pos` or `multi_turn`. It counts completion pulses up to the frame before the last. A wrong frame count therefore shows up as an early pulse, or as a missing pulse that lets the reply end only by timeout. A short low glitch placed before the first frame would shift every byte by one frame if it were taken as a start bit. A reply with a corrupted check byte, one with a bad stop bit and one stopped halfway are each expected to produce exactly one pulse with only the matching flag set. A reply with a short ID after a long one must read back the fields it does not carry as zero. A reply with an unlisted ID must leave earlier results in place.

// File: rtl/enc_rx_pkg.sv
package enc_rx_pkg;

    localparam int BYTE_W     = 8;
    localparam int MAX_FRAMES = 11;
    localparam int FIDX_W     = $clog2(MAX_FRAMES + 1);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [FIDX_W-1:0] fidx_t;

    // Reply layouts, one per group of data IDs sharing a frame order
    typedef enum logic [2:0] {
        LY_NONE,
        LY_ONETURN,
        LY_MULTI,
        LY_IDENT,
        LY_FULL,
        LY_EEPROM
    } layout_e;

    // Destination of one received byte
    typedef enum logic [3:0] {
        FS_SKIP,
        FS_CTRL,
        FS_STAT,
        FS_TURN,
        FS_MTURN,
        FS_IDENT,
        FS_ALARM,
        FS_ADDR,
        FS_EDATA,
        FS_CHECK
    } field_e;

    typedef struct packed {
        field_e     fld;
        logic [1:0] lane;
    } slot_t;

    typedef enum logic [1:0] {
        SM_IDLE,
        SM_START,
        SM_DATA,
        SM_STOP
    } smp_state_e;

    typedef enum logic {
        SQ_IDLE,
        SQ_BUSY
    } seq_state_e;

    function automatic layout_e layout_of(input logic [3:0] id);
        layout_e ly;
        case (id)
            4'h0, 4'h7, 4'h8, 4'hC: ly = LY_ONETURN;
            4'h1:                   ly = LY_MULTI;
            4'h2:                   ly = LY_IDENT;
            4'h3:                   ly = LY_FULL;
            4'h6, 4'hD:             ly = LY_EEPROM;
            default:                ly = LY_NONE;
        endcase
        return ly;
    endfunction

    function automatic fidx_t frames_of(input layout_e ly);
        fidx_t n;
        case (ly)
            LY_ONETURN, LY_MULTI: n = fidx_t'(6);
            LY_IDENT, LY_EEPROM:  n = fidx_t'(4);
            LY_FULL:              n = fidx_t'(MAX_FRAMES);
            default:              n = fidx_t'(0);
        endcase
        return n;
    endfunction

    // Map the frame index of a layout onto a field and byte lane
    function automatic slot_t slot_of(input layout_e ly, input fidx_t idx,
                                      input fidx_t last);
        slot_t s;
        s.fld  = FS_SKIP;
        s.lane = 2'd0;
        if (idx == fidx_t'(0)) begin
            s.fld = FS_CTRL;
        end else if (idx == last) begin
            s.fld = FS_CHECK;
        end else begin
            case (ly)
                LY_ONETURN, LY_MULTI: begin
                    if (idx == fidx_t'(1)) begin
                        s.fld = FS_STAT;
                    end else begin
                        s.fld  = (ly == LY_MULTI) ? FS_MTURN : FS_TURN;
                        s.lane = 2'(idx - fidx_t'(2));
                    end
                end
                LY_IDENT: begin
                    s.fld = (idx == fidx_t'(1)) ? FS_STAT : FS_IDENT;
                end
                LY_EEPROM: begin
                    s.fld = (idx == fidx_t'(1)) ? FS_ADDR : FS_EDATA;
                end
                LY_FULL: begin
                    if (idx == fidx_t'(1)) begin
                        s.fld = FS_STAT;
                    end else if (idx <= fidx_t'(4)) begin
                        s.fld  = FS_TURN;
                        s.lane = 2'(idx - fidx_t'(2));
                    end else if (idx == fidx_t'(5)) begin
                        s.fld = FS_IDENT;
                    end else if (idx <= fidx_t'(8)) begin
                        s.fld  = FS_MTURN;
                        s.lane = 2'(idx - fidx_t'(6));
                    end else begin
                        s.fld = FS_ALARM;
                    end
                end
                default: s.fld = FS_SKIP;
            endcase
        end
        return s;
    endfunction

    // One byte of the x^8+1 check, MSB first
    function automatic byte_t check_step(input byte_t acc, input byte_t din);
        byte_t c;
        logic  fb;
        c = acc;
        for (int j = BYTE_W - 1; j >= 0; j--) begin
            fb = din[j] ^ c[BYTE_W-1];
            c  = {c[BYTE_W-2:0], fb};
        end
        return c;
    endfunction

endpackage

// File: rtl/enc_rx_sampler.sv
module enc_rx_sampler
    import enc_rx_pkg::*;
#(
    parameter int OS_RATE = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  os_tick,
    input  logic  rx,
    output logic  byte_vld,
    output byte_t byte_q,
    output logic  stop_ok
);

    localparam int CNT_W = $clog2(OS_RATE);
    localparam int HALF  = OS_RATE / 2;
    localparam int BIT_W = $clog2(BYTE_W);

    smp_state_e        st;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bitn;
    byte_t             shreg;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st       <= SM_IDLE;
            cnt      <= '0;
            bitn     <= '0;
            shreg    <= '0;
            byte_vld <= 1'b0;
            byte_q   <= '0;
            stop_ok  <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            if (os_tick) begin
                case (st)
                    SM_IDLE: begin
                        if (!rx) begin
                            st  <= SM_START;
                            cnt <= '0;
                        end
                    end
                    SM_START: begin
                        if (cnt == CNT_W'(HALF - 1)) begin
                            cnt  <= '0;
                            bitn <= '0;
                            st   <= rx ? SM_IDLE : SM_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    SM_DATA: begin
                        if (cnt == CNT_W'(OS_RATE - 1)) begin
                            cnt   <= '0;
                            shreg <= {rx, shreg[BYTE_W-1:1]};
                            if (bitn == BIT_W'(BYTE_W - 1)) begin
                                st <= SM_STOP;
                            end else begin
                                bitn <= bitn + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    SM_STOP: begin
                        if (cnt == CNT_W'(OS_RATE - 1)) begin
                            cnt      <= '0;
                            byte_vld <= 1'b1;
                            byte_q   <= shreg;
                            stop_ok  <= rx;
                            st       <= SM_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: st <= SM_IDLE;
                endcase
            end
        end
    end

    // R8
    start_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (en && os_tick && st == SM_START && cnt == CNT_W'(HALF - 1) && rx)
            |=> (st == SM_IDLE && !byte_vld));

    // R12
    byte_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        byte_vld |=> !byte_vld);

endmodule

// File: rtl/enc_rx_check.sv
module enc_rx_check
    import enc_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  upd,
    input  byte_t din,
    output byte_t acc
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
        end else if (upd) begin
            acc <= check_step(acc, din);
        end
    end

endmodule

// File: rtl/enc_rx_fields.sv
module enc_rx_fields
    import enc_rx_pkg::*;
#(
    parameter int POS_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr,
    input  slot_t            slot,
    input  byte_t            din,
    output byte_t            ctrl_q,
    output byte_t            stat_q,
    output logic [POS_W-1:0] turn_q,
    output logic [POS_W-1:0] mturn_q,
    output byte_t            ident_q,
    output byte_t            alarm_q,
    output byte_t            addr_q,
    output byte_t            edata_q,
    output byte_t            check_q
);

    localparam int LANES = POS_W / BYTE_W;

    // Single-byte fields
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ctrl_q  <= '0;
            stat_q  <= '0;
            ident_q <= '0;
            alarm_q <= '0;
            addr_q  <= '0;
            edata_q <= '0;
            check_q <= '0;
        end else if (wr) begin
            case (slot.fld)
                FS_CTRL:  ctrl_q  <= din;
                FS_STAT:  stat_q  <= din;
                FS_IDENT: ident_q <= din;
                FS_ALARM: alarm_q <= din;
                FS_ADDR:  addr_q  <= din;
                FS_EDATA: edata_q <= din;
                FS_CHECK: check_q <= din;
                default:  ;
            endcase
        end
    end

    // Multi-byte fields, one register per byte lane, lane 0 least significant
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                turn_q[l*BYTE_W +: BYTE_W]  <= '0;
                mturn_q[l*BYTE_W +: BYTE_W] <= '0;
            end else if (wr && slot.lane == 2'(l)) begin
                if (slot.fld == FS_TURN) begin
                    turn_q[l*BYTE_W +: BYTE_W] <= din;
                end
                if (slot.fld == FS_MTURN) begin
                    mturn_q[l*BYTE_W +: BYTE_W] <= din;
                end
            end
        end
    end

    // R10
    clear_fields_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (ctrl_q == '0 && stat_q == '0 && turn_q == '0 &&
                 mturn_q == '0 && alarm_q == '0 && check_q == '0));

endmodule

// File: rtl/enc_reply_rx.sv
module enc_reply_rx
    import enc_rx_pkg::*;
#(
    parameter int OS_RATE = 8,
    parameter int TO_W    = 16,
    parameter int POS_W   = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             os_tick,
    input  logic             rx_line,
    input  logic [3:0]       data_id,
    input  logic             start,
    input  logic [TO_W-1:0]  timeout_limit,
    output logic [7:0]       ctrl_field,
    output logic [7:0]       status_field,
    output logic [POS_W-1:0] turn_pos,
    output logic [POS_W-1:0] multi_turn,
    output logic [7:0]       enc_ident,
    output logic [7:0]       alarm_field,
    output logic [7:0]       ee_addr,
    output logic [7:0]       ee_data,
    output logic [7:0]       crc_field,
    output logic             done,
    output logic             crc_ok,
    output logic             frame_err,
    output logic             timeout
);

    seq_state_e       sq;
    layout_e          lay;
    layout_e          lay_in;
    fidx_t            nfr;
    fidx_t            idx;
    fidx_t            last;
    logic [TO_W-1:0]  idle_cnt;

    logic  start_ok;
    logic  at_last;
    logic  good_byte;
    logic  byte_vld;
    logic  stop_ok;
    byte_t byte_q;
    byte_t acc;
    slot_t slot;

    assign lay_in    = layout_of(data_id);
    assign start_ok  = start && (sq == SQ_IDLE) && (lay_in != LY_NONE);
    assign last      = nfr - fidx_t'(1);
    assign at_last   = (idx == last);
    assign good_byte = (sq == SQ_BUSY) && byte_vld && stop_ok;
    assign slot      = slot_of(lay, idx, last);

    enc_rx_sampler #(.OS_RATE(OS_RATE)) u_smp (
        .clk      (clk),
        .rst      (rst),
        .en       (sq == SQ_BUSY),
        .os_tick  (os_tick),
        .rx       (rx_line),
        .byte_vld (byte_vld),
        .byte_q   (byte_q),
        .stop_ok  (stop_ok)
    );

    enc_rx_check u_chk (
        .clk (clk),
        .rst (rst),
        .clr (start_ok),
        .upd (good_byte && !at_last),
        .din (byte_q),
        .acc (acc)
    );

    enc_rx_fields #(.POS_W(POS_W)) u_fld (
        .clk     (clk),
        .rst     (rst),
        .clr     (start_ok),
        .wr      (good_byte),
        .slot    (slot),
        .din     (byte_q),
        .ctrl_q  (ctrl_field),
        .stat_q  (status_field),
        .turn_q  (turn_pos),
        .mturn_q (multi_turn),
        .ident_q (enc_ident),
        .alarm_q (alarm_field),
        .addr_q  (ee_addr),
        .edata_q (ee_data),
        .check_q (crc_field)
    );

    // Reply sequencer: frame counting, completion and fault handling
    always_ff @(posedge clk) begin
        if (rst) begin
            sq        <= SQ_IDLE;
            lay       <= LY_NONE;
            nfr       <= '0;
            idx       <= '0;
            idle_cnt  <= '0;
            done      <= 1'b0;
            crc_ok    <= 1'b0;
            frame_err <= 1'b0;
            timeout   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (sq)
                SQ_IDLE: begin
                    if (start_ok) begin
                        sq        <= SQ_BUSY;
                        lay       <= lay_in;
                        nfr       <= frames_of(lay_in);
                        idx       <= '0;
                        idle_cnt  <= '0;
                        crc_ok    <= 1'b0;
                        frame_err <= 1'b0;
                        timeout   <= 1'b0;
                    end
                end
                SQ_BUSY: begin
                    if (byte_vld) begin
                        idle_cnt <= '0;
                        if (!stop_ok) begin
                            frame_err <= 1'b1;
                            done      <= 1'b1;
                            sq        <= SQ_IDLE;
                        end else if (at_last) begin
                            crc_ok <= (acc == byte_q);
                            done   <= 1'b1;
                            sq     <= SQ_IDLE;
                        end else begin
                            idx <= idx + fidx_t'(1);
                        end
                    end else if (idle_cnt >= timeout_limit) begin
                        timeout <= 1'b1;
                        done    <= 1'b1;
                        sq      <= SQ_IDLE;
                    end else begin
                        idle_cnt <= idle_cnt + 1'b1;
                    end
                end
                default: sq <= SQ_IDLE;
            endcase
        end
    end

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R12
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($countones({crc_ok, frame_err, timeout}) <= 1));

    // R7
    frame_err_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_err) |-> done);

    // R9
    timeout_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout) |-> (done && !crc_ok));

    // R1
    idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (sq == SQ_BUSY) |-> (idx < nfr));

    // R11
    bad_id_chk: assert property (@(posedge clk) disable iff (rst)
        (start && sq == SQ_IDLE && lay_in == LY_NONE) |=> (sq == SQ_IDLE));

endmodule

// File: tb/enc_reply_rx_test.sv
module enc_reply_rx_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        os_tick = 1'b0;
    logic        rx_line = 1'b1;
    logic [3:0]  data_id = 4'h0;
    logic        start = 1'b0;
    logic [15:0] timeout_limit = 16'd400;
    logic [7:0]  ctrl_field, status_field, enc_ident, alarm_field;
    logic [7:0]  ee_addr, ee_data, crc_field;
    logic [23:0] turn_pos, multi_turn;
    logic        done, crc_ok, frame_err, timeout;

    int n_chk = 0;
    int n_bad = 0;
    int done_rise = 0;
    int done_hi = 0;
    int pre_rise = 0;
    logic done_prev = 1'b0;
    logic [7:0] fr [0:10];

    always #2 clk = ~clk;

    enc_reply_rx uut (
        .clk (clk), .rst (rst), .os_tick (os_tick), .rx_line (rx_line),
        .data_id (data_id), .start (start), .timeout_limit (timeout_limit),
        .ctrl_field (ctrl_field), .status_field (status_field),
        .turn_pos (turn_pos), .multi_turn (multi_turn),
        .enc_ident (enc_ident), .alarm_field (alarm_field),
        .ee_addr (ee_addr), .ee_data (ee_data), .crc_field (crc_field),
        .done (done), .crc_ok (crc_ok), .frame_err (frame_err),
        .timeout (timeout)
    );

    initial begin
        forever begin
            @(negedge clk);
            os_tick = ~os_tick;
        end
    end

    always @(negedge clk) begin
        if (done) done_hi <= done_hi + 1;
        if (done && !done_prev) done_rise <= done_rise + 1;
        done_prev <= done;
    end

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stopb);
        rx_line = 1'b0;
        wait_clks(16);
        for (int i = 0; i < 8; i++) begin
            rx_line = b[i];
            wait_clks(16);
        end
        rx_line = stopb;
        wait_clks(16);
        rx_line = 1'b1;
        wait_clks(4);
    endtask

    // Builds the bytes of a reply, last byte = XOR of the others ^ flip,
    // which equals the serial x^8+1 check of R6
    task automatic run_txn(input logic [3:0] id, input int n_total,
                           input int n_send, input int err_frame,
                           input logic [7:0] flip, input logic [7:0] seed,
                           input logic glitch);
        logic [7:0] x;
        x = 8'h00;
        for (int i = 0; i < n_total - 1; i++) begin
            fr[i] = (seed + 8'(i * 43)) ^ 8'(1 << (i % 8));
            x = x ^ fr[i];
        end
        fr[n_total-1] = x ^ flip;
        data_id = id;
        start = 1'b1;
        wait_clks(1);
        start = 1'b0;
        wait_clks(6);
        if (glitch) begin
            rx_line = 1'b0;
            wait_clks(3);
            rx_line = 1'b1;
            wait_clks(30);
        end
        for (int i = 0; i < n_send; i++) begin
            if (i == n_send - 1) pre_rise = done_rise;
            send_frame(fr[i], (i == err_frame) ? 1'b0 : 1'b1);
            if (i == err_frame) break;
        end
        wait_clks(40);
    endtask

    task automatic t_reset;
        chk("R10 reset ctrl", 32'(ctrl_field), 0);
        chk("R10 reset turn", 32'(turn_pos), 0);
        chk("R10 reset flags", {29'd0, crc_ok, frame_err, timeout}, 0);
        chk("R12 reset done", 32'(done), 0);
    endtask

    task automatic t_one_turn(input logic [3:0] id, input logic [7:0] seed);
        int r0, h0;
        r0 = done_rise; h0 = done_hi;
        run_txn(id, 6, 6, -1, 8'h00, seed, 1'b0);
        chk("R1 no early done", 32'(pre_rise), 32'(r0));
        chk("R12 one pulse", 32'(done_rise - r0), 1);
        chk("R12 pulse width", 32'(done_hi - h0), 1);
        chk("R2 ctrl", 32'(ctrl_field), 32'(fr[0]));
        chk("R2 status", 32'(status_field), 32'(fr[1]));
        chk("R2 turn lsb first", 32'(turn_pos), {8'd0, fr[4], fr[3], fr[2]});
        chk("R10 multi cleared", 32'(multi_turn), 0);
        chk("R6 crc ok", 32'(crc_ok), 1);
        chk("R6 crc field", 32'(crc_field), 32'(fr[5]));
    endtask

    task automatic t_multi;
        int r0;
        r0 = done_rise;
        run_txn(4'h1, 6, 6, -1, 8'h00, 8'h3C, 1'b0);
        chk("R3 done", 32'(done_rise - r0), 1);
        chk("R3 multi lsb first", 32'(multi_turn), {8'd0, fr[4], fr[3], fr[2]});
        chk("R3 turn untouched", 32'(turn_pos), 0);
        chk("R3 crc ok", 32'(crc_ok), 1);
    endtask

    task automatic t_full;
        int r0;
        r0 = done_rise;
        run_txn(4'h3, 11, 11, -1, 8'h00, 8'hA5, 1'b0);
        chk("R1 eleven frames no early done", 32'(pre_rise), 32'(r0));
        chk("R1 eleven frames done", 32'(done_rise - r0), 1);
        chk("R4 full status", 32'(status_field), 32'(fr[1]));
        chk("R4 full turn", 32'(turn_pos), {8'd0, fr[4], fr[3], fr[2]});
        chk("R4 full ident", 32'(enc_ident), 32'(fr[5]));
        chk("R4 full multi", 32'(multi_turn), {8'd0, fr[8], fr[7], fr[6]});
        chk("R4 full alarm", 32'(alarm_field), 32'(fr[9]));
        chk("R6 full crc ok", 32'(crc_ok), 1);
    endtask

    task automatic t_ident_glitch;
        int r0;
        r0 = done_rise;
        run_txn(4'h2, 4, 4, -1, 8'h00, 8'h71, 1'b1);
        chk("R8 glitch rejected done", 32'(done_rise - r0), 1);
        chk("R8 glitch rejected ctrl", 32'(ctrl_field), 32'(fr[0]));
        chk("R4 ident", 32'(enc_ident), 32'(fr[2]));
        chk("R4 ident status", 32'(status_field), 32'(fr[1]));
        chk("R10 turn cleared", 32'(turn_pos), 0);
        chk("R10 alarm cleared", 32'(alarm_field), 0);
        chk("R6 ident crc ok", 32'(crc_ok), 1);
    endtask

    task automatic t_eeprom(input logic [3:0] id, input logic [7:0] seed);
        int r0;
        r0 = done_rise;
        run_txn(id, 4, 4, -1, 8'h00, seed, 1'b0);
        chk("R5 done", 32'(done_rise - r0), 1);
        chk("R5 addr", 32'(ee_addr), 32'(fr[1]));
        chk("R5 data", 32'(ee_data), 32'(fr[2]));
        chk("R5 crc field", 32'(crc_field), 32'(fr[3]));
        chk("R10 status cleared", 32'(status_field), 0);
        chk("R5 crc ok", 32'(crc_ok), 1);
    endtask

    task automatic t_crc_bad;
        int r0;
        r0 = done_rise;
        run_txn(4'h8, 6, 6, -1, 8'h5A, 8'h19, 1'b0);
        chk("R6 bad crc done", 32'(done_rise - r0), 1);
        chk("R6 bad crc flag", 32'(crc_ok), 0);
        chk("R6 bad crc field", 32'(crc_field), 32'(fr[5]));
    endtask

    task automatic t_frame_err;
        int r0;
        r0 = done_rise;
        run_txn(4'h3, 11, 11, 2, 8'h00, 8'h44, 1'b0);
        chk("R7 framing done", 32'(done_rise - r0), 1);
        chk("R7 framing flags", {29'd0, crc_ok, frame_err, timeout}, 32'd2);
        chk("R7 ctrl kept", 32'(ctrl_field), 32'(fr[0]));
    endtask

    task automatic t_timeout;
        int r0;
        r0 = done_rise;
        run_txn(4'hC, 6, 2, -1, 8'h00, 8'h0F, 1'b0);
        chk("R9 no done yet", 32'(done_rise - r0), 0);
        wait_clks(600);
        chk("R9 timeout done", 32'(done_rise - r0), 1);
        chk("R9 timeout flags", {29'd0, crc_ok, frame_err, timeout}, 32'd1);
    endtask

    task automatic t_bad_id;
        int r0;
        logic [7:0] c0;
        r0 = done_rise;
        c0 = ctrl_field;
        run_txn(4'h4, 6, 6, -1, 8'h00, 8'hE2, 1'b0);
        wait_clks(500);
        chk("R11 no done", 32'(done_rise - r0), 0);
        chk("R11 ctrl kept", 32'(ctrl_field), 32'(c0));
    endtask

    initial begin
        wait_clks(5);
        rst = 1'b0;
        wait_clks(5);
        t_reset();
        t_one_turn(4'h0, 8'h12);
        t_one_turn(4'h7, 8'h9E);
        t_one_turn(4'h8, 8'h55);
        t_one_turn(4'hC, 8'hF0);
        t_multi();
        t_full();
        t_ident_glitch();
        t_eeprom(4'h6, 8'h21);
        t_eeprom(4'hD, 8'hC3);
        t_crc_bad();
        t_frame_err();
        t_timeout();
        t_one_turn(4'h0, 8'h6B);
        t_bad_id();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule